// File: doc/BRIEF.md
# UART Autobaud Boot Handshake

This block sits on the receive side of a boot link. It watches an idle-high serial input for a single calibration character, 0x40, that the host sends before any payload. From the length of the low run at the front of that character it works out the host's bit period. It turns that period into a 16-bit divisor for a 16x-oversampling UART, checks that the rest of the character has the expected shape, and then locks. A character that fails any check is thrown away, and the block waits for the next falling edge.

Once locked, the block sends a four-byte reply on its own serial output at the rate it detected. The reply is a fixed header byte, the divisor split into two bytes, and a zero terminator. After the fourth byte has left, the block raises its clear-to-send output, which invites the host to stream data. A downstream consumer can drop clear-to-send at any time through a busy input. The lock and the divisor hold until reset.

Top module: `abaud_handshake`

## Requirements
- R1: While reset is held and just after it, `txd` is 1, `cts` is 0, `locked` is 0 and `divisor` is 0.
- R2: For a 0x40 character at P clocks per bit, the block counts the low run, which is 7*P clocks (the start bit and data bits 0 to 5). It then locks with `divisor` = floor((low + 56) / 112), which is the bit period divided by 16 and rounded to the nearest whole number. A locked divisor is never 0.
- R3: After the low run, the block samples three bits at their middles: data bit 6 must be 1, data bit 7 must be 0 and the stop bit must be 1. If any of them is wrong, the block does not lock and waits for a new falling edge.
- R4: A low run shorter than MIN_LOW clocks (default 112) is treated as a glitch. The block does not lock and waits for a new falling edge.
- R5: After lock, `txd` carries four frames in this order: 0xBF, divisor bits 7:0, divisor bits 15:8, then 0x00. Each frame is one 0 start bit, eight data bits sent LSB first, and one 1 stop bit. Every bit lasts divisor*16 clocks.
- R6: `cts` stays 0 until the stop bit of the fourth reply frame has finished. It is never 1 while a reply frame is on `txd`.
- R7: Once the reply is done, `cts` is 0 in the clock cycle after any cycle in which `busy` is 1, and is 1 in the cycle after a cycle in which `busy` is 0.
- R8: Once locked, `locked` stays 1 and `divisor` does not change until reset. Later characters on `rxd` start no new reply.
- R9: `txd` is 1 whenever no reply frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial input from the host, idle high, asynchronous |
| busy | input | 1 | Downstream consumer cannot accept data |
| txd | output | 1 | Serial output carrying the acknowledgement |
| cts | output | 1 | Clear-to-send to the host |
| divisor | output | DIV_W (16) | Divisor that was detected and loaded |
| locked | output | 1 | Rate has been detected and accepted |

## Verification
The measurement is tried at 64, 71, 73 and 300 clocks per bit. Periods of 71 and 73 fall just on either side of a half-step of the divisor, so they show whether the divisor is rounded or truncated. The period of 300 gives a multi-digit divisor with a long acknowledgement. Three rejected inputs precede the first lock, and each hits a different filter: a short low pulse, a 0xC0 character whose bit 7 is wrong, and a 0x40 whose stop bit is low. A valid character sent after those rejections shows that the block rearms. A second character at a different rate after lock shows that the divisor and the reply are frozen.

// File: rtl/abaud_pkg.sv
package abaud_pkg;

    typedef enum logic [1:0] {
        M_IDLE   = 2'd0,
        M_LOW    = 2'd1,
        M_VERIFY = 2'd2,
        M_LOCKED = 2'd3
    } meas_st_t;

    typedef enum logic [1:0] {
        A_WAIT = 2'd0,
        A_LOAD = 2'd1,
        A_SEND = 2'd2,
        A_DONE = 2'd3
    } ack_st_t;

    localparam logic [7:0] ACK_HEAD = 8'hBF;
    localparam logic [7:0] ACK_TAIL = 8'h00;
    localparam int unsigned ACK_BYTES = 4;

endpackage

// File: rtl/abaud_measure.sv
module abaud_measure
    import abaud_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int MIN_LOW = 112
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    output logic             meas_ok,
    output logic [DIV_W-1:0] meas_div
);

    // low run is 7 bits of 16*div clocks: 112*div < 2^(DIV_W+7)
    localparam int LOW_W = DIV_W + 7;
    localparam logic [LOW_W-1:0] MIN_L = LOW_W'(MIN_LOW);
    localparam logic [LOW_W-1:0] MAX_L = LOW_W'(112 * ((1 << DIV_W) - 1) + 55);

    typedef struct packed {
        meas_st_t         st;
        logic             rx_m;
        logic             rx_s;
        logic             rx_p;
        logic [LOW_W-1:0] low;
        logic [LOW_W-1:0] bitp;
        logic [LOW_W-1:0] dcnt;
        logic [1:0]       idx;
        logic             ok;
        logic [DIV_W-1:0] div;
    } meas_t;

    meas_t q, d;

    logic [LOW_W-1:0] per_calc;
    logic [LOW_W-1:0] div_full;
    logic             rise_ok;
    logic             want_bit;

    always_comb begin
        per_calc = (q.low + LOW_W'(3)) / LOW_W'(7);
        div_full = (q.low + LOW_W'(56)) / LOW_W'(112);
        rise_ok  = (q.low >= MIN_L) && (q.low <= MAX_L);
        want_bit = (q.idx != 2'd1);
    end

    always_comb begin
        d      = q;
        d.rx_m = rxd;
        d.rx_s = q.rx_m;
        d.rx_p = q.rx_s;
        d.ok   = 1'b0;
        case (q.st)
            M_IDLE: begin
                if (q.rx_p && !q.rx_s) begin
                    d.st  = M_LOW;
                    d.low = LOW_W'(1);
                end
            end
            M_LOW: begin
                if (!q.rx_s) begin
                    if (q.low > MAX_L) begin
                        d.st = M_IDLE;
                    end else begin
                        d.low = q.low + LOW_W'(1);
                    end
                end else if (!rise_ok) begin
                    d.st = M_IDLE;
                end else begin
                    d.st   = M_VERIFY;
                    d.bitp = per_calc;
                    d.dcnt = per_calc >> 1;
                    d.div  = div_full[DIV_W-1:0];
                    d.idx  = 2'd0;
                end
            end
            M_VERIFY: begin
                if (q.dcnt == '0) begin
                    d.dcnt = q.bitp - LOW_W'(1);
                    d.idx  = q.idx + 2'd1;
                    if (q.rx_s != want_bit) begin
                        d.st = M_IDLE;
                    end else if (q.idx == 2'd2) begin
                        d.st = M_LOCKED;
                        d.ok = 1'b1;
                    end
                end else begin
                    d.dcnt = q.dcnt - LOW_W'(1);
                end
            end
            M_LOCKED: begin
                d.st = M_LOCKED;
            end
            default: d.st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= M_IDLE;
            q.rx_m <= 1'b1;
            q.rx_s <= 1'b1;
            q.rx_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign meas_ok  = q.ok;
    assign meas_div = q.div;

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        meas_ok |-> (meas_div != '0)); // R2

    AST_DIV_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == M_LOW && q.rx_s && rise_ok) |-> (div_full >> DIV_W) == '0); // R2

    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        meas_ok |-> $past(q.rx_s)); // R3

    AST_GLITCH_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == M_LOW && q.rx_s && q.low < MIN_L) |=> (q.st == M_IDLE)); // R4

endmodule

// File: rtl/abaud_tx.sv
module abaud_tx #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       data,
    input  logic [DIV_W-1:0] div,
    output logic             txd,
    output logic             busy,
    output logic             done
);

    localparam int CW = DIV_W + 4;
    localparam int FRAME_BITS = 10;

    typedef struct packed {
        logic                  active;
        logic [FRAME_BITS-1:0] sh;
        logic [3:0]            nbits;
        logic [CW-1:0]         cnt;
        logic                  done;
    } tx_t;

    tx_t q, d;
    logic [CW-1:0] reload;

    always_comb begin
        reload = {div, 4'b0000} - CW'(1);
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (start) begin
                d.active = 1'b1;
                d.sh     = {1'b1, data, 1'b0};
                d.nbits  = 4'(FRAME_BITS - 1);
                d.cnt    = reload;
            end
        end else if (q.cnt == '0) begin
            if (q.nbits == 4'd0) begin
                d.active = 1'b0;
                d.done   = 1'b1;
                d.sh     = '1;
            end else begin
                d.sh    = {1'b1, q.sh[FRAME_BITS-1:1]};
                d.nbits = q.nbits - 4'd1;
                d.cnt   = reload;
            end
        end else begin
            d.cnt = q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.sh <= '1;
        end else begin
            q <= d;
        end
    end

    assign txd  = q.sh[0];
    assign busy = q.active;
    assign done = q.done;

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R9

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd); // R5

    AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R5

endmodule

// File: rtl/abaud_handshake.sv
module abaud_handshake
    import abaud_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int MIN_LOW = 112
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             busy,
    output logic             txd,
    output logic             cts,
    output logic [DIV_W-1:0] divisor,
    output logic             locked
);

    typedef struct packed {
        ack_st_t          st;
        logic [1:0]       idx;
        logic [DIV_W-1:0] div;
        logic             locked;
        logic             cts;
        logic             start;
    } hs_t;

    hs_t q, d;

    logic             meas_ok;
    logic [DIV_W-1:0] meas_div;
    logic             tx_busy;
    logic             tx_done;
    logic [7:0]       ack_byte;
    logic [15:0]      div16;

    abaud_measure #(
        .DIV_W   (DIV_W),
        .MIN_LOW (MIN_LOW)
    ) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxd      (rxd),
        .meas_ok  (meas_ok),
        .meas_div (meas_div)
    );

    always_comb begin
        div16 = 16'(q.div);
        case (q.idx)
            2'd0:    ack_byte = ACK_HEAD;
            2'd1:    ack_byte = div16[7:0];
            2'd2:    ack_byte = div16[15:8];
            default: ack_byte = ACK_TAIL;
        endcase
    end

    abaud_tx #(
        .DIV_W (DIV_W)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (q.start),
        .data  (ack_byte),
        .div   (q.div),
        .txd   (txd),
        .busy  (tx_busy),
        .done  (tx_done)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.cts   = (q.st == A_DONE) && !busy;
        case (q.st)
            A_WAIT: begin
                if (meas_ok) begin
                    d.div    = meas_div;
                    d.locked = 1'b1;
                    d.idx    = 2'd0;
                    d.st     = A_LOAD;
                end
            end
            A_LOAD: begin
                d.start = 1'b1;
                d.st    = A_SEND;
            end
            A_SEND: begin
                if (tx_done) begin
                    if (q.idx == 2'(ACK_BYTES - 1)) begin
                        d.st = A_DONE;
                    end else begin
                        d.idx = q.idx + 2'd1;
                        d.st  = A_LOAD;
                    end
                end
            end
            A_DONE: d.st = A_DONE;
            default: d.st = A_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= A_WAIT;
        end else begin
            q <= d;
        end
    end

    assign cts     = q.cts;
    assign divisor = q.div;
    assign locked  = q.locked;

    AST_CTS_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !cts); // R7

    AST_CTS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        cts |-> (locked && !tx_busy)); // R6

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(divisor))); // R8

    AST_SINGLE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        meas_ok |-> !locked); // R8

endmodule

// File: tb/tb_abaud_handshake.sv
module tb_abaud_handshake;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rxd;
    logic        busy;
    logic        txd;
    logic        cts;
    logic [15:0] divisor;
    logic        locked;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;

    typedef struct {
        logic [7:0] b;
        int         per;
    } item_t;

    item_t exp_q[$];

    always #4 clk = ~clk;

    abaud_handshake dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd     (rxd),
        .busy    (busy),
        .txd     (txd),
        .cts     (cts),
        .divisor (divisor),
        .locked  (locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_ack(input logic [15:0] dv);
        item_t it;
        it.per = int'(dv) * 16;
        it.b = 8'hBF;      exp_q.push_back(it);
        it.b = dv[7:0];    exp_q.push_back(it);
        it.b = dv[15:8];   exp_q.push_back(it);
        it.b = 8'h00;      exp_q.push_back(it);
    endtask

    task automatic send_frame(input logic [7:0] dat, input int per, input logic stopb);
        logic [9:0] f;
        f = {stopb, dat, 1'b0};
        for (int i = 0; i < 10; i++) begin
            rxd = f[i];
            repeat (per) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (per * 2) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rxd   = 1'b1;
        busy  = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        frames_seen = 0;
        exp_q.delete();
    endtask

    task automatic wait_cts(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (cts === 1'b1) break;
            @(negedge clk);
        end
    endtask

    task automatic lock_case(input int per, input logic [15:0] dv);
        do_reset();
        push_ack(dv);
        send_frame(8'h40, per, 1'b1);
        chk("R2 locked", 32'(locked), 32'd1);
        chk("R2 divisor", 32'(divisor), 32'(dv));
        wait_cts(per * 60);
        chk("R6 all frames before cts", 32'(frames_seen), 32'd4);
        chk("R5 queue drained", 32'(exp_q.size()), 32'd0);
        chk("R6 cts raised", 32'(cts), 32'd1);
    endtask

    // monitor: decode frames on txd and compare with the scoreboard queue
    initial begin
        item_t it;
        logic [7:0] got;
        int per;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && txd === 1'b0) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R8 unexpected frame actual=frame expected=idle");
                    it.b = 8'h00;
                    it.per = 64;
                end else begin
                    it = exp_q.pop_front();
                end
                per = it.per;
                repeat (per / 2) @(negedge clk);
                chk("R5 start bit", 32'(txd), 32'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (per) @(negedge clk);
                    got[i] = txd;
                    chk("R6 cts low in frame", 32'(cts), 32'd0);
                end
                repeat (per) @(negedge clk);
                chk("R5 stop bit", 32'(txd), 32'd1);
                chk("R6 cts low at stop", 32'(cts), 32'd0);
                chk("R5 frame byte", 32'(got), 32'(it.b));
                frames_seen++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        rxd   = 1'b1;
        busy  = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 txd", 32'(txd), 32'd1);
        chk("R1 cts", 32'(cts), 32'd0);
        chk("R1 locked", 32'(locked), 32'd0);
        chk("R1 divisor", 32'(divisor), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 txd after release", 32'(txd), 32'd1);
        chk("R9 cts idle", 32'(cts), 32'd0);

        // R4: low pulse shorter than the minimum
        rxd = 1'b0;
        repeat (100) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        chk("R4 glitch no lock", 32'(locked), 32'd0);
        chk("R9 txd idle after glitch", 32'(txd), 32'd1);

        // R3: bit 7 set
        send_frame(8'hC0, 64, 1'b1);
        chk("R3 bad bit7 no lock", 32'(locked), 32'd0);
        // R3: stop bit low
        send_frame(8'h40, 64, 1'b0);
        chk("R3 bad stop no lock", 32'(locked), 32'd0);
        chk("R9 no frames yet", 32'(frames_seen), 32'd0);

        // R2 R5 R6: valid character after rejections
        push_ack(16'd4);
        send_frame(8'h40, 64, 1'b1);
        chk("R2 locked after rearm", 32'(locked), 32'd1);
        chk("R2 divisor 64clk", 32'(divisor), 32'd4);
        chk("R6 cts low during ack", 32'(cts), 32'd0);
        wait_cts(5000);
        chk("R6 frames before cts", 32'(frames_seen), 32'd4);
        chk("R5 queue drained", 32'(exp_q.size()), 32'd0);
        chk("R6 cts high", 32'(cts), 32'd1);

        // R7: busy holds off the host
        busy = 1'b1;
        @(negedge clk);
        chk("R7 cts drops", 32'(cts), 32'd0);
        repeat (3) @(negedge clk);
        chk("R7 cts stays low", 32'(cts), 32'd0);
        busy = 1'b0;
        @(negedge clk);
        chk("R7 cts returns", 32'(cts), 32'd1);

        // R8: later character at another rate is ignored
        send_frame(8'h40, 100, 1'b1);
        repeat (200) @(negedge clk);
        chk("R8 divisor frozen", 32'(divisor), 32'd4);
        chk("R8 still locked", 32'(locked), 32'd1);
        chk("R8 no new reply", 32'(frames_seen), 32'd4);
        chk("R9 txd idle after lock", 32'(txd), 32'd1);

        // R2 rounding on both sides of a half step, then a larger divisor
        lock_case(73, 16'd5);
        lock_case(71, 16'd4);
        lock_case(300, 16'd19);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule